// File: doc/BRIEF.md
# 8-bit PWM Timer/Counter

An 8-bit timer/counter with a single output-compare channel. It drives one waveform output and runs in one of four waveform modes:
- free-running normal counting;
- clear-on-compare, where the compare value sets the period;
- single-slope fast PWM;
- dual-slope phase-correct PWM.

The counter moves only on cycles where the count-enable tick is high. A clock prescaler upstream therefore sets the counting rate.

Software-facing state is written through simple write strobes:
- a configuration write loads the waveform mode and the two-bit output action field;
- a compare write loads the compare value.

The compare value is double-buffered in the two PWM modes and takes effect at a mode-dependent point. In the other modes it takes effect at once. An overflow flag and a compare flag record events until they are cleared by write-one-to-clear strobes. The output-active signal tells the surrounding pin logic when the waveform should replace the pin's ordinary function.

Top module: `pwm_timer8`

## Requirements
- R1: Reset clears the counter, the active and buffered compare values, the waveform, both flags, the mode (to 0) and the output action (to 00). Reset is asynchronous and active low.
- R2: The counter changes only on cycles with `tick` high. In mode 0 (normal) and mode 3 (fast PWM) it counts up by one and wraps from 0xFF to 0x00.
- R3: In mode 2 (clear on compare), a tick taken while the count equals the active compare value returns the count to 0x00. Otherwise the count rises by one and wraps at 0xFF. In modes 0 and 2, a compare write becomes the active compare value on the next cycle.
- R4: In mode 1 (phase correct), the count rises to 0xFF, then falls to 0x00, then rises again, visiting each end once. A full period is 510 ticks. A compare write becomes active only after a tick taken at count 0xFF. Leaving mode 1 resets the direction to up.
- R5: In mode 3, a compare write becomes active only after a tick taken at count 0xFF, which is the wrap to BOTTOM. If a write arrives on that same cycle, the written value is the one loaded.
- R6: `ovf_flag` is set by a tick at count 0xFF in modes 0, 2 and 3. In mode 1 it is set by a tick at count 0x00 while counting down.
- R7: `cmp_flag` is set by any tick taken while the count equals the active compare value.
- R8: `flag_clr[0]` clears `ovf_flag` and `flag_clr[1]` clears `cmp_flag`. A set on the same cycle wins over the clear.
- R9: In modes 0 and 2, a compare match acts on the waveform according to the output action: 00 does nothing, 01 toggles, 10 clears, 11 sets.
- R10: In mode 3, action 10 clears the waveform on a match and sets it on the tick at 0xFF. Action 11 does the reverse. Actions 00 and 01 leave it unchanged.
- R11: In mode 3, when the active compare value is 0xFF and action bit 1 is set, the match is ignored. Only the 0xFF-tick action applies, so the output is constant: high for 10, low for 11.
- R12: In mode 1, action 10 clears the waveform on a match while counting up and sets it on a match while counting down. Action 11 does the reverse. Actions 00 and 01 leave it unchanged.
- R13: `wave_en` is high when the action is nonzero, except for action 01 in modes 1 and 3. `wave_out` follows the waveform when `wave_en` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; the counter steps on cycles where it is high |
| cfg_we | input | 1 | Loads `cfg_mode` and `cfg_com` |
| cfg_mode | input | 2 | Waveform mode: 0 normal, 1 phase correct, 2 clear on compare, 3 fast PWM |
| cfg_com | input | 2 | Output action field |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 compare |
| count_out | output | 8 | Current count |
| wave_out | output | 1 | Waveform output |
| wave_en | output | 1 | Waveform should override the pin |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |

## Verification
The bench drives compare writes mid-period in both PWM modes. A design that loaded the compare value at once would produce a glitched pulse width, and one that loaded it at the wrong end would shift the new width by half a period. It runs fast PWM with the compare value at 0xFF, where honouring the match would make the output flicker for one count instead of staying constant. It also runs phase-correct mode across both turnarounds, where an off-by-one at an end gives a 508- or 512-tick period or sets the overflow flag at the top. Finally, it makes flag clears collide with flag sets and switches modes while the counter is falling.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;
    typedef enum logic [1:0] {
        WG_NORMAL = 2'd0,
        WG_PHASE  = 2'd1,
        WG_CTC    = 2'd2,
        WG_FAST   = 2'd3
    } wg_mode_e;

    typedef enum logic [1:0] {
        CO_OFF    = 2'd0,
        CO_TOGGLE = 2'd1,
        CO_CLEAR  = 2'd2,
        CO_SET    = 2'd3
    } co_mode_e;
endpackage

// File: rtl/pwm_t8_counter.sv
module pwm_t8_counter
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wg_mode_e     mode,
    input  logic [W-1:0] top_cmp,
    output logic [W-1:0] cnt_q,
    output logic         down_q
);
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mode != WG_PHASE) s_d.down = 1'b0;
        if (tick) begin
            unique case (mode)
                WG_CTC: begin
                    s_d.cnt = (s_q.cnt == top_cmp) ? '0 : s_q.cnt + 1'b1;
                end
                WG_PHASE: begin
                    if (!s_q.down) begin
                        if (s_q.cnt == MAXV) begin
                            s_d.down = 1'b1;
                            s_d.cnt  = s_q.cnt - 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else begin
                        if (s_q.cnt == '0) begin
                            s_d.down = 1'b0;
                            s_d.cnt  = s_q.cnt + 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt - 1'b1;
                        end
                    end
                end
                default: s_d.cnt = s_q.cnt + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_q  = s_q.cnt;
    assign down_q = s_q.down;

    // R2: no tick, no movement
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    // R4: falling phase never sits at the top
    a_r4_down_below_top: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_PHASE && down_q) |-> (cnt_q != MAXV));
endmodule

// File: rtl/pwm_t8_compare.sv
module pwm_t8_compare
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wg_mode_e     mode,
    input  logic [W-1:0] cnt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ocr_q,
    output logic         match
);
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] act;
    } cmp_st_t;

    cmp_st_t s_d, s_q;
    logic    immediate;
    logic    load_pt;

    always_comb begin
        immediate = (mode == WG_NORMAL) || (mode == WG_CTC);
        load_pt   = tick && (cnt == MAXV);
        s_d       = s_q;
        if (wr_en) s_d.pend = wr_data;
        if (immediate) begin
            if (wr_en) s_d.act = wr_data;
        end else if (load_pt) begin
            s_d.act = wr_en ? wr_data : s_q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ocr_q = s_q.act;
    assign match = tick && (cnt == s_q.act);

    // R5: buffered value only moves at the wrap in fast PWM
    a_r5_fast_load_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_FAST && !(tick && cnt == MAXV)) |=> $stable(ocr_q));
endmodule

// File: rtl/pwm_t8_wave.sv
module pwm_t8_wave
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wg_mode_e     mode,
    input  co_mode_e     com,
    input  logic [W-1:0] cnt,
    input  logic         down,
    input  logic [W-1:0] ocr,
    input  logic         match,
    output logic         wave_q,
    output logic         drive_en
);
    localparam logic [W-1:0] MAXV = '1;

    logic wave_d;
    logic pwm_mode;

    always_comb begin
        pwm_mode = (mode == WG_PHASE) || (mode == WG_FAST);
        drive_en = (com != CO_OFF) && !(pwm_mode && com == CO_TOGGLE);
        wave_d   = wave_q;
        unique case (mode)
            WG_FAST: begin
                if (com[1]) begin
                    if (tick && cnt == MAXV)            wave_d = (com == CO_CLEAR);
                    else if (match && ocr != MAXV)      wave_d = (com == CO_SET);
                end
            end
            WG_PHASE: begin
                if (com[1] && match) wave_d = down ? (com == CO_CLEAR) : (com == CO_SET);
            end
            default: begin
                if (match) begin
                    unique case (com)
                        CO_TOGGLE: wave_d = ~wave_q;
                        CO_CLEAR:  wave_d = 1'b0;
                        CO_SET:    wave_d = 1'b1;
                        default:   wave_d = wave_q;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    // R9: toggle action flips on every match
    a_r9_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == WG_NORMAL || mode == WG_CTC) && com == CO_TOGGLE && match)
        |=> (wave_q != $past(wave_q)));

    // R11: compare at top in fast PWM never moves the output mid-period
    a_r11_top_match_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_FAST && com[1] && ocr == MAXV && !(tick && cnt == MAXV))
        |=> $stable(wave_q));
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_mode,
    input  logic [1:0]   cfg_com,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic [1:0]   flag_clr,
    output logic [W-1:0] count_out,
    output logic         wave_out,
    output logic         wave_en,
    output logic         ovf_flag,
    output logic         cmp_flag
);
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        wg_mode_e mode;
        co_mode_e com;
        logic     ovf;
        logic     cmf;
    } top_st_t;

    top_st_t      s_d, s_q;
    logic [W-1:0] cnt;
    logic         down;
    logic [W-1:0] ocr;
    logic         match;
    logic         wave;
    logic         drive;
    logic         ovf_set;

    pwm_t8_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(s_q.mode),
        .top_cmp(ocr), .cnt_q(cnt), .down_q(down)
    );

    pwm_t8_compare #(.W(W)) u_compare (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(s_q.mode), .cnt(cnt),
        .wr_en(cmp_we), .wr_data(cmp_wdata), .ocr_q(ocr), .match(match)
    );

    pwm_t8_wave #(.W(W)) u_wave (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(s_q.mode), .com(s_q.com),
        .cnt(cnt), .down(down), .ocr(ocr), .match(match),
        .wave_q(wave), .drive_en(drive)
    );

    always_comb begin
        ovf_set = tick && ((s_q.mode != WG_PHASE && cnt == MAXV) ||
                           (s_q.mode == WG_PHASE && down && cnt == '0));
        s_d     = s_q;
        if (cfg_we) begin
            s_d.mode = wg_mode_e'(cfg_mode);
            s_d.com  = co_mode_e'(cfg_com);
        end
        s_d.ovf = (s_q.ovf && !flag_clr[0]) || ovf_set;
        s_d.cmf = (s_q.cmf && !flag_clr[1]) || match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_out = cnt;
    assign wave_en   = drive;
    assign wave_out  = drive & wave;
    assign ovf_flag  = s_q.ovf;
    assign cmp_flag  = s_q.cmf;

    // R7: a match always leaves the compare flag set
    a_r7_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_flag);

    // R8: clear without a coincident event empties the overflow flag
    a_r8_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[0] && !ovf_set) |=> !ovf_flag);

    // R6: phase-correct top does not raise overflow
    a_r6_pc_top_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == WG_PHASE && tick && cnt == MAXV && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/test_pwm_timer8.sv
module test_pwm_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [1:0] cfg_com = 2'd0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic [1:0] flag_clr = 2'd0;
    logic [7:0] count_out;
    logic       wave_out, wave_en, ovf_flag, cmp_flag;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    int m_cnt, m_dir, m_pend, m_ocr, m_wave, m_ovf, m_cmf, m_mode, m_com;

    always #2 clk = ~clk;

    pwm_timer8 i_pwm_timer8 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_com(cfg_com), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
        .count_out(count_out), .wave_out(wave_out), .wave_en(wave_en),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_en();
        if (m_com == 0) return 0;
        if ((m_mode == 1 || m_mode == 3) && m_com == 1) return 0;
        return 1;
    endfunction

    // reference next-state from inputs presented before the edge
    task automatic model_edge();
        int n_cnt = m_cnt, n_dir = m_dir, n_ocr = m_ocr, n_wave = m_wave;
        int mt = (tick && m_cnt == m_ocr) ? 1 : 0;
        int ov = 0;
        if (tick) begin
            if (m_mode == 1) ov = (m_dir == 1 && m_cnt == 0) ? 1 : 0;
            else             ov = (m_cnt == 255) ? 1 : 0;
        end
        if (m_mode != 1) n_dir = 0;
        if (tick) begin
            case (m_mode)
                2: n_cnt = (m_cnt == m_ocr) ? 0 : (m_cnt + 1) % 256;
                1: begin
                    if (m_dir == 0) begin
                        if (m_cnt == 255) begin n_dir = 1; n_cnt = 254; end
                        else n_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin n_dir = 0; n_cnt = 1; end
                        else n_cnt = m_cnt - 1;
                    end
                end
                default: n_cnt = (m_cnt + 1) % 256;
            endcase
        end
        if (m_mode == 0 || m_mode == 2) begin
            if (cmp_we) n_ocr = cmp_wdata;
        end else if (tick && m_cnt == 255) begin
            n_ocr = cmp_we ? int'(cmp_wdata) : m_pend;
        end
        case (m_mode)
            3: if (m_com >= 2) begin
                if (tick && m_cnt == 255) n_wave = (m_com == 2) ? 1 : 0;
                else if (mt && m_ocr != 255) n_wave = (m_com == 3) ? 1 : 0;
            end
            1: if (m_com >= 2 && mt) begin
                if (m_dir == 1) n_wave = (m_com == 2) ? 1 : 0;
                else            n_wave = (m_com == 3) ? 1 : 0;
            end
            default: if (mt) begin
                if (m_com == 1) n_wave = 1 - m_wave;
                else if (m_com == 2) n_wave = 0;
                else if (m_com == 3) n_wave = 1;
            end
        endcase
        m_ovf  = ((m_ovf == 1 && !flag_clr[0]) || ov == 1) ? 1 : 0;
        m_cmf  = ((m_cmf == 1 && !flag_clr[1]) || mt == 1) ? 1 : 0;
        if (cmp_we) m_pend = cmp_wdata;
        if (cfg_we) begin m_mode = cfg_mode; m_com = cfg_com; end
        m_cnt = n_cnt; m_dir = n_dir; m_ocr = n_ocr; m_wave = n_wave;
    endtask

    task automatic compare_all(bit cleared);
        string ct, wt;
        ct = (m_mode == 2) ? "R3 count" : (m_mode == 1) ? "R4 count" : "R2 count";
        if (m_mode == 3) wt = (m_ocr == 255) ? "R11 wave" : "R10 wave";
        else if (m_mode == 1) wt = "R12 wave";
        else wt = "R9 wave";
        chk(ct, count_out, m_cnt);
        chk(cleared ? "R8 ovf" : "R6 ovf", ovf_flag, m_ovf);
        chk(cleared ? "R8 cmf" : (m_mode == 3 ? "R5 R7 cmf" : "R7 cmf"), cmp_flag, m_cmf);
        chk("R13 wave_en", wave_en, exp_en());
        chk(wt, wave_out, exp_en() ? m_wave : 0);
    endtask

    // one clock: present inputs at a falling edge, compare at the next one
    task automatic cyc(bit t, bit cw, int md, int cm, bit pw, int pd, int clr);
        tick = t; cfg_we = cw; cfg_mode = md[1:0]; cfg_com = cm[1:0];
        cmp_we = pw; cmp_wdata = pd[7:0]; flag_clr = clr[1:0];
        model_edge();
        @(negedge clk);
        compare_all(clr != 0);
        tick = 0; cfg_we = 0; cmp_we = 0; flag_clr = 0;
    endtask

    task automatic setup(int md, int cm, int ocr);
        cyc(0, 1, md, cm, 1, ocr, 0);
    endtask

    task automatic run(int n, int tick_gap);
        for (int i = 0; i < n; i++)
            cyc((tick_gap == 0) || (i % tick_gap != 0), 0, 0, 0, 0, 0, (i % 37 == 5) ? 3 : 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_cnt = 0; m_dir = 0; m_pend = 0; m_ocr = 0; m_wave = 0;
        m_ovf = 0; m_cmf = 0; m_mode = 0; m_com = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 count", count_out, 0);
        chk("R1 flags", {ovf_flag, cmp_flag}, 0);
        chk("R1 wave", {wave_en, wave_out}, 0);

        // normal mode, toggle, with gaps in tick
        setup(0, 1, 8'h40);
        run(700, 3);
        cyc(1, 0, 0, 0, 1, 8'h10, 0);   // R3 immediate write in normal mode
        run(300, 0);
        setup(0, 2, 8'h20); run(300, 0);
        setup(0, 3, 8'h90); run(300, 0);

        // clear on compare
        setup(2, 1, 9);
        run(60, 0);
        cyc(1, 0, 0, 0, 1, 3, 0);
        run(60, 0);
        cyc(1, 0, 0, 0, 1, 8'hFF, 0);
        run(300, 4);

        // R5: fast PWM, non-inverting, mid-period compare write
        setup(3, 2, 8'h80);
        run(400, 0);
        cyc(1, 0, 0, 0, 1, 8'h30, 0);
        run(600, 0);
        // write coincident with the wrap
        while (count_out != 8'hFF) cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 1, 8'hC0, 0);
        run(300, 0);
        // R11: compare at top, both polarities
        setup(3, 2, 8'hFF); run(700, 0);
        setup(3, 3, 8'hFF); run(700, 0);
        setup(3, 3, 8'h10); run(600, 0);
        // R10: reserved action keeps pin disconnected
        setup(3, 1, 8'h50); run(300, 0);

        // R4: phase correct, period and buffered load at top
        setup(1, 2, 8'h30);
        while (count_out != 8'h00) cyc(1, 0, 0, 0, 0, 0, 0);
        begin
            int t0;
            t0 = 0;
            cyc(1, 0, 0, 0, 0, 0, 0); t0++;
            while (count_out != 8'h00) begin cyc(1, 0, 0, 0, 0, 0, 0); t0++; end
            chk("R4 period", t0, 510);
        end
        cyc(1, 0, 0, 0, 1, 8'hA0, 0);
        run(1100, 0);
        setup(1, 3, 8'h00); run(1100, 5);
        setup(1, 2, 8'hFF); run(1100, 0);
        // leave phase correct while falling
        while (count_out != 8'h80) cyc(1, 0, 0, 0, 0, 0, 0);
        setup(0, 1, 8'h85);
        run(400, 0);
        // R8: clear colliding with set
        setup(0, 2, 8'h05);
        while (count_out != 8'hFF) cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 1);
        chk("R8 set wins over clear", ovf_flag, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R8 clear", ovf_flag, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule